// File: doc/BRIEF.md
# Selectable Texture Filtering Unit

This block turns already-fetched texels into one filtered RGB colour per request. For each request it takes the 2x2 texel quad of a finer mip level (level n), the 2x2 quad of the next coarser level (level n-1), the fractional texture coordinates uf and vf, the level fraction lf and a filter mode. It returns the filtered 24-bit colour together with a valid flag.

The same datapath serves three filter modes, chosen per request at run time. Nearest mode returns the texel of level n that the bilinear weights favour most. Bilinear mode forms a weighted blend of the four texels of level n. Trilinear mode blends the bilinear results of both levels using lf. Registers that the chosen mode does not need are not loaded, so idle parts of the pipeline do not toggle. Memory fetch, texel addressing and level-of-detail computation happen outside this block.

Every request takes the same fixed three-cycle latency, whatever its mode. A new request may be issued on every cycle, and the modes may be freely interleaved.

Top module: `tex_filter_unit`

## Requirements
- R1: While rst_n is low, out_valid and out_rgb are both 0.
- R2: out_valid is high exactly 3 clock edges after the edge that sampled in_valid high, in every mode. It is low otherwise.
- R3: Bilinear mode (in_mode 1) uses the one-axis weights a0=256-uf, a1=uf, b0=256-vf and b1=vf. Texel k gets the weight W0=a0*b0, W1=a1*b0, W2=a1*b1 or W3=a0*b1. Each channel is (sum of texel*W + 32768) >> 16.
- R4: Nearest mode (in_mode 0) returns the level-n texel with the largest weight from R3. On a tie, the lowest texel index wins.
- R5: Trilinear mode (in_mode 2) computes the R3 result A for level n and the R3 result B for level n-1. Each channel is (A*(256-lf) + B*lf + 128) >> 8.
- R6: in_mode 3 behaves exactly like bilinear mode. In nearest and bilinear modes, the level n-1 texels and lf have no effect on the output.
- R7: Texel k occupies bits [24k+23:24k] of its level bus. Inside a texel and in out_rgb, red is in bits [23:16], green in [15:8] and blue in [7:0]. Each channel is filtered on its own.
- R8: The mode, fractions and texels are captured with each request, so back-to-back requests in different modes each follow their own mode.
- R9: Every channel result is clamped to 255. Full-intensity texels give 255 for any fractions.
- R10: While out_valid is low, out_rgb keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | 0 nearest, 1 bilinear, 2 trilinear, 3 bilinear |
| in_uf | input | 8 | Horizontal fraction, 256 = 1.0 |
| in_vf | input | 8 | Vertical fraction, 256 = 1.0 |
| in_lf | input | 8 | Level fraction, 256 = 1.0 |
| lvl_a_texels | input | 96 | Four level-n texels, texel k at bits 24k+23:24k |
| lvl_b_texels | input | 96 | Four level n-1 texels, same packing |
| out_valid | output | 1 | Filtered colour valid |
| out_rgb | output | 24 | Filtered colour, R in 23:16, G in 15:8, B in 7:0 |

## Verification
Every result, in any mode, is due on the third rising edge after the edge that samples its request. The bench drives each request on a falling edge. It then reads the outputs on the third falling edge after that one, which is half a cycle after the result lands. A behavioural model pushes one expected entry per falling edge into a three-deep queue and pops the oldest entry for comparison. This matches valid, colour and the held value of idle cycles on every clock, with no regard to how the stages are built inside the block.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
   typedef enum logic [1:0] {
      FILT_NEAREST = 2'd0,
      FILT_BILIN   = 2'd1,
      FILT_TRILIN  = 2'd2,
      FILT_BILIN_B = 2'd3
   } filt_mode_e;

   localparam int unsigned PIPE_LAT = 3;
endpackage

// File: rtl/tfu_weight_gen.sv
module tfu_weight_gen #(
   parameter int unsigned FRAC_W = 8
) (
   input  logic [FRAC_W-1:0]              uf,
   input  logic [FRAC_W-1:0]              vf,
   output logic [3:0][2*FRAC_W:0]         wts,
   output logic [1:0]                     pick
);
   localparam int unsigned WT_W = FRAC_W + 1;
   localparam int unsigned W2_W = 2 * FRAC_W + 1;
   localparam logic [WT_W-1:0] ONE = WT_W'(1) << FRAC_W;

   logic [WT_W-1:0] ua0, ua1, vb0, vb1;

   assign ua1 = WT_W'(uf);
   assign vb1 = WT_W'(vf);
   assign ua0 = ONE - ua1;
   assign vb0 = ONE - vb1;

   always_comb begin
      wts[0] = W2_W'(W2_W'(ua0) * W2_W'(vb0));
      wts[1] = W2_W'(W2_W'(ua1) * W2_W'(vb0));
      wts[2] = W2_W'(W2_W'(ua1) * W2_W'(vb1));
      wts[3] = W2_W'(W2_W'(ua0) * W2_W'(vb1));
   end

   // strict compare keeps the lowest index on ties
   always_comb begin
      pick = 2'd0;
      for (int k = 1; k < 4; k++) begin
         if (wts[k] > wts[pick]) pick = 2'(k);
      end
   end
endmodule

// File: rtl/tfu_bilerp.sv
module tfu_bilerp #(
   parameter int unsigned CH_W   = 8,
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned FRAC_W = 8
) (
   input  logic [4*CH_W*NUM_CH-1:0]  texels,
   input  logic [3:0][2*FRAC_W:0]    wts,
   output logic [CH_W*NUM_CH-1:0]    result
);
   localparam int unsigned TEXEL_W = CH_W * NUM_CH;
   localparam int unsigned W2_W    = 2 * FRAC_W + 1;
   localparam int unsigned ACC_W   = CH_W + W2_W + 2;
   localparam int unsigned SH      = 2 * FRAC_W;
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SH - 1);
   localparam logic [ACC_W-1:0] MAXV = ACC_W'((1 << CH_W) - 1);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] scaled;

      always_comb begin
         acc = '0;
         for (int k = 0; k < 4; k++) begin
            acc = acc + ACC_W'(ACC_W'(texels[k*TEXEL_W + ch*CH_W +: CH_W]) * ACC_W'(wts[k]));
         end
      end

      assign scaled = (acc + HALF) >> SH;
      assign result[ch*CH_W +: CH_W] = (scaled > MAXV) ? MAXV[CH_W-1:0] : scaled[CH_W-1:0];
   end
endmodule

// File: rtl/tfu_lod_blend.sv
module tfu_lod_blend #(
   parameter int unsigned CH_W   = 8,
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned FRAC_W = 8
) (
   input  logic [CH_W*NUM_CH-1:0] near_rgb,
   input  logic [CH_W*NUM_CH-1:0] far_rgb,
   input  logic [FRAC_W-1:0]      lf,
   output logic [CH_W*NUM_CH-1:0] result
);
   localparam int unsigned ACC_W = CH_W + FRAC_W + 2;
   localparam logic [ACC_W-1:0] ONE  = ACC_W'(1) << FRAC_W;
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);
   localparam logic [ACC_W-1:0] MAXV = ACC_W'((1 << CH_W) - 1);

   logic [ACC_W-1:0] w_far, w_near;
   assign w_far  = ACC_W'(lf);
   assign w_near = ONE - w_far;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] scaled;

      assign acc = ACC_W'(ACC_W'(near_rgb[ch*CH_W +: CH_W]) * w_near)
                 + ACC_W'(ACC_W'(far_rgb[ch*CH_W +: CH_W]) * w_far);
      assign scaled = (acc + HALF) >> FRAC_W;
      assign result[ch*CH_W +: CH_W] = (scaled > MAXV) ? MAXV[CH_W-1:0] : scaled[CH_W-1:0];
   end
endmodule

// File: rtl/tex_filter_unit.sv
module tex_filter_unit #(
   parameter int unsigned CH_W      = 8,
   parameter int unsigned NUM_CH    = 3,
   parameter int unsigned FRAC_W    = 8,
   parameter bit          GATE_IDLE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [1:0]                   in_mode,
   input  logic [FRAC_W-1:0]            in_uf,
   input  logic [FRAC_W-1:0]            in_vf,
   input  logic [FRAC_W-1:0]            in_lf,
   input  logic [4*CH_W*NUM_CH-1:0]     lvl_a_texels,
   input  logic [4*CH_W*NUM_CH-1:0]     lvl_b_texels,
   output logic                         out_valid,
   output logic [CH_W*NUM_CH-1:0]       out_rgb
);
   import tfu_pkg::*;

   localparam int unsigned TEXEL_W = CH_W * NUM_CH;
   localparam int unsigned QUAD_W  = 4 * TEXEL_W;

   if (CH_W < 1 || CH_W > 16) begin : g_bad_ch
      $error("tex_filter_unit: CH_W must be 1..16");
   end
   if (NUM_CH < 1) begin : g_bad_num
      $error("tex_filter_unit: NUM_CH must be at least 1");
   end
   if (FRAC_W < 2 || FRAC_W > 14) begin : g_bad_frac
      $error("tex_filter_unit: FRAC_W must be 2..14");
   end

   // ---------------- stage 0: weights and nearest pick ----------------
   logic [3:0][2*FRAC_W:0] w_now;
   logic [1:0]             pick_now;
   filt_mode_e             mode_now;

   assign mode_now = filt_mode_e'(in_mode);

   tfu_weight_gen #(.FRAC_W(FRAC_W)) u_wgen (
      .uf   (in_uf),
      .vf   (in_vf),
      .wts  (w_now),
      .pick (pick_now)
   );

   logic is_tri_now;
   assign is_tri_now = (mode_now == FILT_TRILIN);

   logic en_a1, en_b1;
   if (GATE_IDLE) begin : g_gate1
      assign en_a1 = in_valid;
      assign en_b1 = in_valid && is_tri_now;
   end else begin : g_free1
      assign en_a1 = in_valid;
      assign en_b1 = in_valid;
   end

   // ---------------- stage 1 registers ----------------
   logic                   s1_valid;
   filt_mode_e             s1_mode;
   logic [3:0][2*FRAC_W:0] s1_wts;
   logic [1:0]             s1_pick;
   logic [QUAD_W-1:0]      s1_tex_a;
   logic [QUAD_W-1:0]      s1_tex_b;
   logic [FRAC_W-1:0]      s1_lf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= FILT_NEAREST;
         s1_wts   <= '0;
         s1_pick  <= '0;
         s1_tex_a <= '0;
      end else begin
         s1_valid <= in_valid;
         if (en_a1) begin
            s1_mode  <= mode_now;
            s1_wts   <= w_now;
            s1_pick  <= pick_now;
            s1_tex_a <= lvl_a_texels;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_tex_b <= '0;
         s1_lf    <= '0;
      end else if (en_b1) begin
         s1_tex_b <= lvl_b_texels;
         s1_lf    <= in_lf;
      end
   end

   // ---------------- stage 1 datapath: two bilinear units ----------------
   logic [TEXEL_W-1:0] bil_a, bil_b;

   tfu_bilerp #(.CH_W(CH_W), .NUM_CH(NUM_CH), .FRAC_W(FRAC_W)) u_bil_a (
      .texels (s1_tex_a),
      .wts    (s1_wts),
      .result (bil_a)
   );

   tfu_bilerp #(.CH_W(CH_W), .NUM_CH(NUM_CH), .FRAC_W(FRAC_W)) u_bil_b (
      .texels (s1_tex_b),
      .wts    (s1_wts),
      .result (bil_b)
   );

   logic s1_is_near, s1_is_tri;
   assign s1_is_near = (s1_mode == FILT_NEAREST);
   assign s1_is_tri  = (s1_mode == FILT_TRILIN);

   logic en_near2, en_a2, en_b2;
   if (GATE_IDLE) begin : g_gate2
      assign en_near2 = s1_valid && s1_is_near;
      assign en_a2    = s1_valid && !s1_is_near;
      assign en_b2    = s1_valid && s1_is_tri;
   end else begin : g_free2
      assign en_near2 = s1_valid;
      assign en_a2    = s1_valid;
      assign en_b2    = s1_valid;
   end

   // ---------------- stage 2 registers ----------------
   logic               s2_valid;
   filt_mode_e         s2_mode;
   logic [TEXEL_W-1:0] s2_near;
   logic [TEXEL_W-1:0] s2_bil_a;
   logic [TEXEL_W-1:0] s2_bil_b;
   logic [FRAC_W-1:0]  s2_lf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_mode  <= FILT_NEAREST;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) s2_mode <= s1_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_near  <= '0;
         s2_bil_a <= '0;
         s2_bil_b <= '0;
         s2_lf    <= '0;
      end else begin
         if (en_near2) s2_near <= s1_tex_a[int'(s1_pick)*TEXEL_W +: TEXEL_W];
         if (en_a2)    s2_bil_a <= bil_a;
         if (en_b2) begin
            s2_bil_b <= bil_b;
            s2_lf    <= s1_lf;
         end
      end
   end

   // ---------------- stage 2 datapath: level blend and mode select ----------------
   logic [TEXEL_W-1:0] tri_rgb;
   logic [TEXEL_W-1:0] sel_rgb;

   tfu_lod_blend #(.CH_W(CH_W), .NUM_CH(NUM_CH), .FRAC_W(FRAC_W)) u_blend (
      .near_rgb (s2_bil_a),
      .far_rgb  (s2_bil_b),
      .lf       (s2_lf),
      .result   (tri_rgb)
   );

   always_comb begin
      unique case (s2_mode)
         FILT_NEAREST: sel_rgb = s2_near;
         FILT_TRILIN:  sel_rgb = tri_rgb;
         default:      sel_rgb = s2_bil_a;
      endcase
   end

   // ---------------- stage 3: output ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) out_rgb <= sel_rgb;
      end
   end
endmodule

// File: rtl/tfu_checker.sv
module tfu_checker #(
   parameter int unsigned CH_W   = 8,
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned FRAC_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [1:0]               in_mode,
   input logic [4*CH_W*NUM_CH-1:0] lvl_a_texels,
   input logic [4*CH_W*NUM_CH-1:0] lvl_b_texels,
   input logic                     out_valid,
   input logic [CH_W*NUM_CH-1:0]   out_rgb
);
   localparam int unsigned TEXEL_W = CH_W * NUM_CH;

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   function automatic bit in_span(input logic [TEXEL_W-1:0] o,
                                  input logic [8*TEXEL_W-1:0] t);
      bit ok = 1'b1;
      for (int ch = 0; ch < int'(NUM_CH); ch++) begin
         int lo = (1 << CH_W) - 1;
         int hi = 0;
         int v;
         for (int k = 0; k < 8; k++) begin
            v = int'(t[k*TEXEL_W + ch*CH_W +: CH_W]);
            if (v < lo) lo = v;
            if (v > hi) hi = v;
         end
         v = int'(o[ch*CH_W +: CH_W]);
         if (v < lo || v > hi) ok = 1'b0;
      end
      return ok;
   endfunction

   function automatic bit is_one_of(input logic [TEXEL_W-1:0] o,
                                    input logic [4*TEXEL_W-1:0] t);
      bit hit = 1'b0;
      for (int k = 0; k < 4; k++) begin
         if (o == t[k*TEXEL_W +: TEXEL_W]) hit = 1'b1;
      end
      return hit;
   endfunction

   // R1: cleared outputs during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (out_valid == 1'b0 && out_rgb == '0)
            else $error("R1 outputs not clear in reset");
      end
   end

   assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   assert_nearest_is_texel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid, 3) && $past(in_mode, 3) == 2'd0)
      |-> is_one_of(out_rgb, $past(lvl_a_texels, 3)));

   assert_bilinear_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid, 3) && ($past(in_mode, 3) == 2'd1 || $past(in_mode, 3) == 2'd3))
      |-> in_span(out_rgb, {$past(lvl_a_texels, 3), $past(lvl_a_texels, 3)}));

   assert_trilinear_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(in_valid, 3) && $past(in_mode, 3) == 2'd2)
      |-> in_span(out_rgb, {$past(lvl_b_texels, 3), $past(lvl_a_texels, 3)}));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !out_valid) |-> $stable(out_rgb));
endmodule

bind tex_filter_unit tfu_checker #(
   .CH_W   (CH_W),
   .NUM_CH (NUM_CH),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_mode      (in_mode),
   .lvl_a_texels (lvl_a_texels),
   .lvl_b_texels (lvl_b_texels),
   .out_valid    (out_valid),
   .out_rgb      (out_rgb)
);

// File: tb/sim_tex_filter_unit.sv
module sim_tex_filter_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_mode = 2'd0;
   logic [7:0]  in_uf = 8'd0, in_vf = 8'd0, in_lf = 8'd0;
   logic [95:0] lvl_a_texels = '0, lvl_b_texels = '0;
   logic        out_valid;
   logic [23:0] out_rgb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tex_filter_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_uf(in_uf), .in_vf(in_vf), .in_lf(in_lf),
      .lvl_a_texels(lvl_a_texels), .lvl_b_texels(lvl_b_texels),
      .out_valid(out_valid), .out_rgb(out_rgb)
   );

   typedef struct {
      bit          v;
      logic [23:0] d;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [23:0] last_d = '0;

   // ---- behavioural reference ----
   function automatic int wt(int k, int uf, int vf);
      int a0 = 256 - uf, a1 = uf, b0 = 256 - vf, b1 = vf;
      case (k)
         0: return a0 * b0;
         1: return a1 * b0;
         2: return a1 * b1;
         default: return a0 * b1;
      endcase
   endfunction

   function automatic logic [23:0] bilin(logic [95:0] t, int uf, int vf);
      logic [23:0] r;
      for (int ch = 0; ch < 3; ch++) begin
         longint s = 0;
         for (int k = 0; k < 4; k++) s += longint'(t[k*24 + ch*8 +: 8]) * wt(k, uf, vf);
         s = (s + 32768) >>> 16;
         if (s > 255) s = 255;
         r[ch*8 +: 8] = 8'(s);
      end
      return r;
   endfunction

   function automatic logic [23:0] model(int mode, int uf, int vf, int lf,
                                         logic [95:0] ta, logic [95:0] tb);
      logic [23:0] a, b, r;
      if (mode == 0) begin
         int best = 0;
         for (int k = 1; k < 4; k++) if (wt(k, uf, vf) > wt(best, uf, vf)) best = k;
         return ta[best*24 +: 24];
      end
      a = bilin(ta, uf, vf);
      if (mode != 2) return a;
      b = bilin(tb, uf, vf);
      for (int ch = 0; ch < 3; ch++) begin
         int s = int'(a[ch*8 +: 8]) * (256 - lf) + int'(b[ch*8 +: 8]) * lf;
         s = (s + 128) >> 8;
         if (s > 255) s = 255;
         r[ch*8 +: 8] = 8'(s);
      end
      return r;
   endfunction

   function automatic logic [23:0] px(int r, int g, int b);
      return {8'(r), 8'(g), 8'(b)};
   endfunction

   function automatic logic [95:0] rnd_quad();
      return {$urandom(), $urandom(), $urandom()};
   endfunction

   // ---- compare the oldest expectation against the ports ----
   task automatic check_out();
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.v) begin
         if (out_valid !== 1'b1 || out_rgb !== e.d) begin
            errors++;
            $display("FAIL %s (R2 timing): valid=%0b rgb=%06h expected valid=1 rgb=%06h",
                     e.tag, out_valid, out_rgb, e.d);
         end
         last_d = e.d;
      end else begin
         if (out_valid !== 1'b0 || out_rgb !== last_d) begin
            errors++;
            $display("FAIL %s: valid=%0b rgb=%06h expected valid=0 rgb=%06h",
                     e.tag, out_valid, out_rgb, last_d);
         end
      end
   endtask

   task automatic step(bit v, int mode, int uf, int vf, int lf,
                       logic [95:0] ta, logic [95:0] tb, string tag);
      exp_t e;
      @(negedge clk);
      check_out();
      e.v   = v;
      e.d   = v ? model(mode, uf, vf, lf, ta, tb) : 24'h0;
      e.tag = v ? tag : "R2/R10 idle";
      q.push_back(e);
      in_valid     = v;
      in_mode      = 2'(mode);
      in_uf        = 8'(uf);
      in_vf        = 8'(vf);
      in_lf        = 8'(lf);
      lvl_a_texels = ta;
      lvl_b_texels = tb;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, '0, '0, "");
   endtask

   initial begin
      logic [95:0] qa, qb;
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
            errors++;
            $display("FAIL R1: valid=%0b rgb=%06h expected valid=0 rgb=000000", out_valid, out_rgb);
         end
      end
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         exp_t f;
         f.v = 1'b0; f.d = '0; f.tag = "R1/R10 after reset";
         q.push_back(f);
      end

      qa = {px(200, 10, 90), px(30, 150, 60), px(255, 0, 128), px(0, 255, 40)};
      qb = {px(5, 5, 5), px(250, 250, 250), px(100, 20, 200), px(60, 70, 80)};

      // R3 bilinear at corners, centre and off-centre
      step(1, 1, 0,   0,   0,  qa, qb, "R3 corner");
      step(1, 1, 128, 128, 0,  qa, qb, "R3 centre");
      step(1, 1, 37,  201, 0,  qa, qb, "R3 skew");
      step(1, 1, 255, 255, 0,  qa, qb, "R3 max frac");
      idle(2);
      // R4 nearest including ties
      step(1, 0, 128, 128, 0,  qa, qb, "R4 four-way tie -> texel 0");
      step(1, 0, 200, 128, 0,  qa, qb, "R4 tie 1/2 -> texel 1");
      step(1, 0, 200, 200, 0,  qa, qb, "R4 texel 2");
      step(1, 0, 10,  250, 0,  qa, qb, "R4 texel 3");
      step(1, 0, 128, 10,  0,  qa, qb, "R4 tie 0/1 -> texel 0");
      // R5 trilinear
      step(1, 2, 77,  140, 0,   qa, qb, "R5 lf=0");
      step(1, 2, 77,  140, 128, qa, qb, "R5 lf=half");
      step(1, 2, 77,  140, 255, qa, qb, "R5 lf=max");
      // R6 mode 3 and ignored level n-1 / lf
      step(1, 3, 90,  33,  17,  qa, rnd_quad(), "R6 mode 3");
      step(1, 1, 90,  33,  250, qa, rnd_quad(), "R6 bilinear ignores level n-1");
      step(1, 0, 90,  33,  99,  qa, rnd_quad(), "R6 nearest ignores level n-1");
      // R7 channel isolation
      step(1, 1, 64, 192, 0, {px(0, 0, 255), px(0, 255, 0), px(255, 0, 0), px(0, 0, 0)}, qb,
           "R7 channel layout");
      // R9 clamp at full scale
      step(1, 1, 1, 255, 0, {4{24'hFFFFFF}}, qb, "R9 white bilinear");
      step(1, 2, 3, 7, 129, {4{24'hFFFFFF}}, {4{24'hFFFFFF}}, "R9 white trilinear");
      // R10 hold across idle
      idle(5);
      // R8 interleaved modes back to back
      for (int i = 0; i < 24; i++)
         step(1, i % 4, (i * 37) % 256, (i * 91) % 256, (i * 53) % 256, rnd_quad(), rnd_quad(),
              "R8 interleaved");
      // mixed random traffic with gaps
      for (int i = 0; i < 400; i++)
         step(($urandom() % 4) != 0, $urandom() % 4, $urandom() % 256, $urandom() % 256,
              $urandom() % 256, rnd_quad(), rnd_quad(), "R3/R4/R5 random");
      idle(4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule